// File: doc/BRIEF.md
# Channel Exit Sequencer

This block takes a channel-program processor out of its running channel when either of two events happens: an execution error, or a debug instruction that has been set to halt. Each event triggers a fixed exit sequence. The block records what happened in a status record. It then streams the channel's context back to context memory, one word per accepted cycle, over a valid/ready port. For errors that did not come from the bus, it finally raises a prioritised interrupt to the host and waits until the host queue accepts it.

The two sequences differ in four ways: which status fields they update, whether the channel-enable bit is cleared or kept, whether the saved program counter is stepped back to the debug instruction, and whether the global enable is dropped. While a sequence runs, `busy` holds the processor stalled. This includes the time spent waiting on a full interrupt queue, so repeated errors can never flood the host. A one-cycle `done` pulse marks the end of each sequence. Only the faulting channel is stopped. Once `busy` falls, the processor may go on to other channels.

Top module: `chan_exit_seq`

## Requirements
- R1: On an accepted error trigger, the error PC, error channel, error type and bus flag fields take `cur_pc`, `cur_chan`, `err_type` and `err_bus`. The debug PC and debug channel fields keep their values.
- R2: On an accepted debug trigger, the debug PC and debug channel fields take `cur_pc` and `cur_chan`. All error fields keep their values.
- R3: The context save sends 8 words when `ctx_size`=0, 4 when `ctx_size`=1, and 2 when `ctx_size` is 2 or 3. `ctx_idx` counts 0,1,… and `ctx_last` is high only on the final word. Every word carries the channel number that was captured at the trigger.
- R4: For an error exit, and for a debug exit with `dbg_ret`=0, the saved `ctx_cen` is 0 and the saved `ctx_pc` is `cur_pc`. For a debug exit with `dbg_ret`=1, `ctx_cen` equals `cur_cen` and `ctx_pc` is `cur_pc`−1, wrapping modulo 2^PCW.
- R5: An error exit with `err_bus`=0 raises `irq_req` after the last context word is accepted. `irq_lvl` equals the `irq_prio` value captured at the trigger, and `irq_req` stays high until `irq_rdy`. Bus errors and debug exits raise no interrupt.
- R6: `busy` is high from the cycle after an accepted trigger until the cycle after the one-cycle `done` pulse. It stays high for as long as an interrupt is pending without `irq_rdy`.
- R7: A debug exit with `dbg_evt`=1 gives exactly one one-cycle `bkpt` pulse. No other exit pulses `bkpt`.
- R8: A debug exit with `dbg_dall`=1 clears `glob_en`. `glob_en` resets to 1 and is set again only by `host_en_set`. Other exits leave it unchanged.
- R9: Triggers that arrive while `busy` is high are ignored. When both triggers arrive in the same idle cycle, the error sequence runs and the debug trigger is dropped.
- R10: While `ctx_vld` is high and `ctx_rdy` is low, `ctx_vld`, `ctx_idx`, `ctx_pc`, `ctx_cen` and `ctx_chan` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_trig | input | 1 | Error exit request |
| err_type | input | ETW | Error type code |
| err_bus | input | 1 | Error came from the system bus |
| dbg_trig | input | 1 | Halting debug instruction executed |
| dbg_ret | input | 1 | Keep channel enabled, rewind PC to the debug instruction |
| dbg_evt | input | 1 | Emit breakpoint pulse |
| dbg_dall | input | 1 | Disable all channels (clear global enable) |
| cur_pc | input | PCW | PC of the current instruction |
| cur_chan | input | CHW | Active channel number |
| cur_cen | input | 1 | Current channel-enable bit |
| ctx_size | input | 2 | Context size select: 0 full, 1 small, 2/3 minimum |
| irq_prio | input | PRW | Programmed error interrupt priority |
| host_en_set | input | 1 | Host sets global enable |
| ctx_vld | output | 1 | Context word valid |
| ctx_rdy | input | 1 | Context memory accepts word |
| ctx_idx | output | IDXW | Index of context word |
| ctx_pc | output | PCW | Saved PC value |
| ctx_cen | output | 1 | Saved channel-enable value |
| ctx_chan | output | CHW | Channel whose context is saved |
| ctx_last | output | 1 | Final context word |
| irq_req | output | 1 | Interrupt request to host queue |
| irq_rdy | input | 1 | Host queue accepts request |
| irq_lvl | output | PRW | Priority of the request |
| bkpt | output | 1 | Breakpoint pulse |
| glob_en | output | 1 | Global processor enable |
| busy | output | 1 | Exit in progress, processor stalled |
| done | output | 1 | Exit finished (one cycle) |
| st_err_pc | output | PCW | Status: error PC |
| st_err_chan | output | CHW | Status: error channel |
| st_err_type | output | ETW | Status: error type |
| st_err_bus | output | 1 | Status: bus error flag |
| st_dbg_pc | output | PCW | Status: debug PC |
| st_dbg_chan | output | CHW | Status: debug channel |

## Verification
On every cycle, the embedded properties check the following: context words stay steady under back-pressure, the word index steps up, an interrupt request stays up until accepted, `busy` drops after `done`, breakpoint pulses last one cycle, and a disable-all debug exit clears the global enable. Some behaviours can be shown only by the bench's scenarios: the exact save length for each size code, the saved PC and enable values including the PC wrap, which status fields change for which exit, the absence of an interrupt for bus errors and debug exits, error-over-debug priority, and the dropping of triggers during a running exit.

// File: rtl/chan_exit_pkg.sv
package chan_exit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_IRQ  = 2'd2,
    ST_FIN  = 2'd3
  } exit_st_t;

  localparam logic [1:0] CSZ_FULL  = 2'd0;
  localparam logic [1:0] CSZ_SMALL = 2'd1;

  // number of context words for a size code; codes 2 and 3 both mean minimum
  function automatic int unsigned save_words(input logic [1:0] sz,
                                             input int unsigned full_n,
                                             input int unsigned small_n,
                                             input int unsigned min_n);
    case (sz)
      CSZ_FULL:  return full_n;
      CSZ_SMALL: return small_n;
      default:   return min_n;
    endcase
  endfunction

endpackage

// File: rtl/exit_fsm.sv
module exit_fsm
  import chan_exit_pkg::*;
#(
  parameter int PRW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           err_trig,
  input  logic           dbg_trig,
  input  logic           err_bus,
  input  logic [PRW-1:0] irq_prio,
  input  logic           save_done,
  input  logic           irq_rdy,
  output logic           start_err,
  output logic           start_dbg,
  output logic           in_save,
  output logic           irq_req,
  output logic [PRW-1:0] irq_lvl,
  output logic           busy,
  output logic           done
);

  exit_st_t       st, st_nx;
  logic           need_irq;
  logic [PRW-1:0] lvl_q;

  assign start_err = (st == ST_IDLE) && err_trig;
  assign start_dbg = (st == ST_IDLE) && dbg_trig && !err_trig;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start_err || start_dbg) st_nx = ST_SAVE;
      ST_SAVE: if (save_done) st_nx = need_irq ? ST_IRQ : ST_FIN;
      ST_IRQ:  if (irq_rdy) st_nx = ST_FIN;
      ST_FIN:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      need_irq <= 1'b0;
      lvl_q    <= '0;
    end else begin
      st <= st_nx;
      if (start_err || start_dbg) begin
        need_irq <= start_err && !err_bus;
        lvl_q    <= irq_prio;
      end
    end
  end

  assign in_save = (st == ST_SAVE);
  assign irq_req = (st == ST_IRQ);
  assign irq_lvl = lvl_q;
  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_FIN);

  // R5: a pending request and its level hold until accepted
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_rdy |=> irq_req && $stable(irq_lvl));

  // R5: the interrupt only follows a completed context save
  assert_irq_after_save_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(in_save) && $past(save_done));

  // R6: done is a single cycle and releases the stall
  assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

endmodule

// File: rtl/ctx_stream.sv
module ctx_stream
  import chan_exit_pkg::*;
#(
  parameter int PCW         = 16,
  parameter int CHW         = 5,
  parameter int FULL_WORDS  = 8,
  parameter int SMALL_WORDS = 4,
  parameter int MIN_WORDS   = 2,
  localparam int IDXW       = (FULL_WORDS > 1) ? $clog2(FULL_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_dbg,
  input  logic            dbg_ret,
  input  logic [1:0]      ctx_size,
  input  logic [PCW-1:0]  cur_pc,
  input  logic [CHW-1:0]  cur_chan,
  input  logic            cur_cen,
  input  logic            in_save,
  input  logic            ctx_rdy,
  output logic            ctx_vld,
  output logic [IDXW-1:0] ctx_idx,
  output logic [PCW-1:0]  ctx_pc,
  output logic            ctx_cen,
  output logic [CHW-1:0]  ctx_chan,
  output logic            ctx_last,
  output logic            save_done
);

  logic [IDXW-1:0] idx_q, top_q;
  logic [PCW-1:0]  pc_q;
  logic            cen_q;
  logic [CHW-1:0]  chan_q;
  logic            keep;

  assign keep = is_dbg && dbg_ret;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      top_q  <= '0;
      pc_q   <= '0;
      cen_q  <= 1'b0;
      chan_q <= '0;
    end else if (start) begin
      idx_q  <= '0;
      top_q  <= IDXW'(save_words(ctx_size, FULL_WORDS, SMALL_WORDS, MIN_WORDS) - 1);
      pc_q   <= keep ? cur_pc - PCW'(1) : cur_pc;
      cen_q  <= keep ? cur_cen : 1'b0;
      chan_q <= cur_chan;
    end else if (in_save && ctx_rdy && (idx_q != top_q)) begin
      idx_q <= idx_q + IDXW'(1);
    end
  end

  assign ctx_vld   = in_save;
  assign ctx_idx   = idx_q;
  assign ctx_pc    = pc_q;
  assign ctx_cen   = cen_q;
  assign ctx_chan  = chan_q;
  assign ctx_last  = in_save && (idx_q == top_q);
  assign save_done = ctx_last && ctx_rdy;

  // R10: a stalled word keeps its contents
  assert_vld_hold_R10: assert property (@(posedge clk) disable iff (rst)
    ctx_vld && !ctx_rdy |=> ctx_vld && $stable(ctx_idx) && $stable(ctx_pc)
                            && $stable(ctx_cen) && $stable(ctx_chan));

  // R3: accepted non-final word advances the index by one
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (rst)
    ctx_vld && ctx_rdy && !ctx_last |=> ctx_vld && ctx_idx == $past(ctx_idx) + IDXW'(1));

endmodule

// File: rtl/exit_status.sv
module exit_status #(
  parameter int PCW = 16,
  parameter int CHW = 5,
  parameter int ETW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_err,
  input  logic           start_dbg,
  input  logic [PCW-1:0] cur_pc,
  input  logic [CHW-1:0] cur_chan,
  input  logic [ETW-1:0] err_type,
  input  logic           err_bus,
  input  logic           dbg_evt,
  input  logic           dbg_dall,
  input  logic           host_en_set,
  output logic [PCW-1:0] st_err_pc,
  output logic [CHW-1:0] st_err_chan,
  output logic [ETW-1:0] st_err_type,
  output logic           st_err_bus,
  output logic [PCW-1:0] st_dbg_pc,
  output logic [CHW-1:0] st_dbg_chan,
  output logic           bkpt,
  output logic           glob_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_err_pc   <= '0;
      st_err_chan <= '0;
      st_err_type <= '0;
      st_err_bus  <= 1'b0;
      st_dbg_pc   <= '0;
      st_dbg_chan <= '0;
      bkpt        <= 1'b0;
      glob_en     <= 1'b1;
    end else begin
      bkpt <= start_dbg && dbg_evt;
      if (start_err) begin
        st_err_pc   <= cur_pc;
        st_err_chan <= cur_chan;
        st_err_type <= err_type;
        st_err_bus  <= err_bus;
      end
      if (start_dbg) begin
        st_dbg_pc   <= cur_pc;
        st_dbg_chan <= cur_chan;
      end
      if (start_dbg && dbg_dall) glob_en <= 1'b0;
      else if (host_en_set)      glob_en <= 1'b1;
    end
  end

  // R7: breakpoint never lasts more than one cycle
  assert_bkpt_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    bkpt |=> !bkpt);

  // R8: disable-all debug exit drops the global enable
  assert_glob_clear_R8: assert property (@(posedge clk) disable iff (rst)
    start_dbg && dbg_dall |=> !glob_en);

endmodule

// File: rtl/chan_exit_seq.sv
module chan_exit_seq #(
  parameter int PCW         = 16,
  parameter int CHW         = 5,
  parameter int ETW         = 3,
  parameter int PRW         = 8,
  parameter int FULL_WORDS  = 8,
  parameter int SMALL_WORDS = 4,
  parameter int MIN_WORDS   = 2,
  localparam int IDXW       = (FULL_WORDS > 1) ? $clog2(FULL_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            err_trig,
  input  logic [ETW-1:0]  err_type,
  input  logic            err_bus,
  input  logic            dbg_trig,
  input  logic            dbg_ret,
  input  logic            dbg_evt,
  input  logic            dbg_dall,
  input  logic [PCW-1:0]  cur_pc,
  input  logic [CHW-1:0]  cur_chan,
  input  logic            cur_cen,
  input  logic [1:0]      ctx_size,
  input  logic [PRW-1:0]  irq_prio,
  input  logic            host_en_set,
  output logic            ctx_vld,
  input  logic            ctx_rdy,
  output logic [IDXW-1:0] ctx_idx,
  output logic [PCW-1:0]  ctx_pc,
  output logic            ctx_cen,
  output logic [CHW-1:0]  ctx_chan,
  output logic            ctx_last,
  output logic            irq_req,
  input  logic            irq_rdy,
  output logic [PRW-1:0]  irq_lvl,
  output logic            bkpt,
  output logic            glob_en,
  output logic            busy,
  output logic            done,
  output logic [PCW-1:0]  st_err_pc,
  output logic [CHW-1:0]  st_err_chan,
  output logic [ETW-1:0]  st_err_type,
  output logic            st_err_bus,
  output logic [PCW-1:0]  st_dbg_pc,
  output logic [CHW-1:0]  st_dbg_chan
);

  logic start_err, start_dbg, in_save, save_done;

  exit_fsm #(.PRW(PRW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .err_trig  (err_trig),
    .dbg_trig  (dbg_trig),
    .err_bus   (err_bus),
    .irq_prio  (irq_prio),
    .save_done (save_done),
    .irq_rdy   (irq_rdy),
    .start_err (start_err),
    .start_dbg (start_dbg),
    .in_save   (in_save),
    .irq_req   (irq_req),
    .irq_lvl   (irq_lvl),
    .busy      (busy),
    .done      (done)
  );

  ctx_stream #(
    .PCW(PCW), .CHW(CHW),
    .FULL_WORDS(FULL_WORDS), .SMALL_WORDS(SMALL_WORDS), .MIN_WORDS(MIN_WORDS)
  ) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .start     (start_err || start_dbg),
    .is_dbg    (start_dbg),
    .dbg_ret   (dbg_ret),
    .ctx_size  (ctx_size),
    .cur_pc    (cur_pc),
    .cur_chan  (cur_chan),
    .cur_cen   (cur_cen),
    .in_save   (in_save),
    .ctx_rdy   (ctx_rdy),
    .ctx_vld   (ctx_vld),
    .ctx_idx   (ctx_idx),
    .ctx_pc    (ctx_pc),
    .ctx_cen   (ctx_cen),
    .ctx_chan  (ctx_chan),
    .ctx_last  (ctx_last),
    .save_done (save_done)
  );

  exit_status #(.PCW(PCW), .CHW(CHW), .ETW(ETW)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .start_err   (start_err),
    .start_dbg   (start_dbg),
    .cur_pc      (cur_pc),
    .cur_chan    (cur_chan),
    .err_type    (err_type),
    .err_bus     (err_bus),
    .dbg_evt     (dbg_evt),
    .dbg_dall    (dbg_dall),
    .host_en_set (host_en_set),
    .st_err_pc   (st_err_pc),
    .st_err_chan (st_err_chan),
    .st_err_type (st_err_type),
    .st_err_bus  (st_err_bus),
    .st_dbg_pc   (st_dbg_pc),
    .st_dbg_chan (st_dbg_chan),
    .bkpt        (bkpt),
    .glob_en     (glob_en)
  );

  // R9: a running exit is never restarted by a new trigger
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);

endmodule

// File: tb/sim_chan_exit_seq.sv
`timescale 1ns/1ps
module sim_chan_exit_seq;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic err_trig, err_bus, dbg_trig, dbg_ret, dbg_evt, dbg_dall, cur_cen, host_en_set;
  logic [2:0] err_type;
  logic [15:0] cur_pc;
  logic [4:0] cur_chan;
  logic [1:0] ctx_size;
  logic [7:0] irq_prio;
  logic ctx_vld, ctx_rdy, ctx_cen, ctx_last, irq_req, irq_rdy, bkpt, glob_en, busy, done;
  logic [2:0] ctx_idx;
  logic [15:0] ctx_pc;
  logic [4:0] ctx_chan;
  logic [7:0] irq_lvl;
  logic [15:0] st_err_pc, st_dbg_pc;
  logic [4:0] st_err_chan, st_dbg_chan;
  logic [2:0] st_err_type;
  logic st_err_bus;

  chan_exit_seq u0 (
    .clk(clk), .rst(rst), .err_trig(err_trig), .err_type(err_type), .err_bus(err_bus),
    .dbg_trig(dbg_trig), .dbg_ret(dbg_ret), .dbg_evt(dbg_evt), .dbg_dall(dbg_dall),
    .cur_pc(cur_pc), .cur_chan(cur_chan), .cur_cen(cur_cen), .ctx_size(ctx_size),
    .irq_prio(irq_prio), .host_en_set(host_en_set), .ctx_vld(ctx_vld), .ctx_rdy(ctx_rdy),
    .ctx_idx(ctx_idx), .ctx_pc(ctx_pc), .ctx_cen(ctx_cen), .ctx_chan(ctx_chan),
    .ctx_last(ctx_last), .irq_req(irq_req), .irq_rdy(irq_rdy), .irq_lvl(irq_lvl),
    .bkpt(bkpt), .glob_en(glob_en), .busy(busy), .done(done),
    .st_err_pc(st_err_pc), .st_err_chan(st_err_chan), .st_err_type(st_err_type),
    .st_err_bus(st_err_bus), .st_dbg_pc(st_dbg_pc), .st_dbg_chan(st_dbg_chan)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [15:0] pc;
    logic        cen;
    logic [4:0]  chan;
    logic        last;
  } witem_t;

  witem_t exp_q[$];
  int total = 0, bad = 0;
  int irq_cnt, bkpt_cnt, word_cnt, stall_bad;
  int irq_delay = 0, rdy_mode = 0, cyc = 0, wcnt = 0;
  logic [7:0] exp_lvl;
  logic [15:0] e_err_pc, e_dbg_pc;
  logic [4:0] e_err_chan, e_dbg_chan;
  logic [2:0] e_err_type;
  logic e_err_bus;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: drive readies, then pop expected words on each handshake
  always @(negedge clk) begin
    cyc++;
    ctx_rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    if (irq_req) begin
      wcnt++;
      irq_rdy = (wcnt > irq_delay);
    end else begin
      wcnt = 0;
      irq_rdy = 1'b0;
    end
    if (!rst) begin
      if (ctx_vld && ctx_rdy) begin
        word_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R3 extra word", 32'(ctx_idx), 32'hffff);
        else begin
          witem_t w, a;
          w = exp_q.pop_front();
          a = '{idx: ctx_idx, pc: ctx_pc, cen: ctx_cen, chan: ctx_chan, last: ctx_last};
          chk(a == w, "R3/R4 context word", 32'(a), 32'(w));
        end
      end
      if (irq_req && irq_rdy) begin
        irq_cnt++;
        chk(irq_lvl == exp_lvl, "R5 irq level", 32'(irq_lvl), 32'(exp_lvl));
      end
      if (irq_req && !irq_rdy && !busy) stall_bad++;
      if (bkpt) bkpt_cnt++;
    end
  end

  task automatic run_exit(input bit e, input bit d, input bit ebus, input logic [2:0] code,
                          input logic [15:0] pc, input logic [4:0] ch, input bit cen,
                          input logic [1:0] sz, input bit ret, input bit evt, input bit dall,
                          input logic [7:0] prio, input bit mid_dbg, input string tag);
    int n;
    bit is_dbg, got;
    logic [15:0] spc;
    bit scen;
    is_dbg = d && !e;
    n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 4 : 2;
    spc = (is_dbg && ret) ? pc - 16'd1 : pc;
    scen = (is_dbg && ret) ? cen : 1'b0;
    for (int i = 0; i < n; i++)
      exp_q.push_back('{idx: 3'(i), pc: spc, cen: scen, chan: ch, last: (i == n - 1)});
    irq_cnt = 0; bkpt_cnt = 0; word_cnt = 0; stall_bad = 0;
    exp_lvl = prio;
    if (e) begin
      e_err_pc = pc; e_err_chan = ch; e_err_type = code; e_err_bus = ebus;
    end else if (d) begin
      e_dbg_pc = pc; e_dbg_chan = ch;
    end
    @(negedge clk);
    err_trig = e; dbg_trig = d; err_bus = ebus; err_type = code; cur_pc = pc;
    cur_chan = ch; cur_cen = cen; ctx_size = sz; dbg_ret = ret; dbg_evt = evt;
    dbg_dall = dall; irq_prio = prio;
    @(negedge clk);
    err_trig = 0; dbg_trig = 0;
    irq_prio = ~prio; cur_pc = ~pc; cur_chan = ~ch;
    chk(busy == 1'b1, {"R6 busy after trigger ", tag}, 32'(busy), 32'd1);
    got = 0;
    for (int k = 0; k < 300 && !got; k++) begin
      if (mid_dbg && k == 2) begin
        dbg_trig = 1; dbg_evt = 1; dbg_dall = 1; err_trig = 1;
      end
      if (mid_dbg && k == 3) begin
        dbg_trig = 0; err_trig = 0;
      end
      if (done) got = 1;
      else @(negedge clk);
    end
    chk(got, {"R6 done seen ", tag}, 32'(got), 32'd1);
    @(negedge clk);
    dbg_dall = 0; dbg_evt = 0;
    chk(!done && !busy, {"R6 released after done ", tag}, 32'({done, busy}), 32'd0);
    chk(exp_q.size() == 0 && word_cnt == n, {"R3 word count ", tag}, 32'(word_cnt), 32'(n));
    exp_q.delete();
    chk(irq_cnt == ((e && !ebus) ? 1 : 0), {"R5 irq count ", tag}, 32'(irq_cnt), 32'(e && !ebus));
    chk(stall_bad == 0, {"R6 stall while irq pending ", tag}, 32'(stall_bad), 32'd0);
    chk(bkpt_cnt == ((is_dbg && evt) ? 1 : 0), {"R7 bkpt pulses ", tag}, 32'(bkpt_cnt), 32'(is_dbg && evt));
    chk({st_err_pc, st_err_chan, st_err_type, st_err_bus} == {e_err_pc, e_err_chan, e_err_type, e_err_bus},
        {"R1 error status ", tag}, 32'({st_err_pc, st_err_chan, st_err_type, st_err_bus}),
        32'({e_err_pc, e_err_chan, e_err_type, e_err_bus}));
    chk({st_dbg_pc, st_dbg_chan} == {e_dbg_pc, e_dbg_chan}, {"R2 debug status ", tag},
        32'({st_dbg_pc, st_dbg_chan}), 32'({e_dbg_pc, e_dbg_chan}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; err_trig = 0; dbg_trig = 0; err_bus = 0; err_type = 0; dbg_ret = 0;
    dbg_evt = 0; dbg_dall = 0; cur_pc = 0; cur_chan = 0; cur_cen = 0; ctx_size = 0;
    irq_prio = 0; host_en_set = 0; ctx_rdy = 1; irq_rdy = 0;
    e_err_pc = 0; e_err_chan = 0; e_err_type = 0; e_err_bus = 0; e_dbg_pc = 0; e_dbg_chan = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !ctx_vld && !irq_req && !bkpt && !done, "R6 reset idle",
        32'({busy, ctx_vld, irq_req, bkpt, done}), 32'd0);
    chk(glob_en == 1'b1, "R8 reset global enable", 32'(glob_en), 32'd1);
    chk(st_err_pc == 0 && st_dbg_pc == 0, "R1 reset status", 32'(st_err_pc), 32'd0);

    // R1 R3 R4 R5: error, full context, back-pressure, slow interrupt queue
    rdy_mode = 1; irq_delay = 4;
    run_exit(1, 0, 0, 3'd5, 16'h1234, 5'd7, 1, 2'd0, 0, 0, 0, 8'h5a, 0, "err full");
    // R5: bus error raises no interrupt, small context
    rdy_mode = 0; irq_delay = 0;
    run_exit(1, 0, 1, 3'd2, 16'h0400, 5'd3, 1, 2'd1, 1, 1, 1, 8'h11, 0, "bus err");
    chk(glob_en == 1'b1, "R8 error leaves global enable", 32'(glob_en), 32'd1);
    // R2 R4 R7: debug, no return, event pulse, minimum size
    run_exit(0, 1, 0, 3'd0, 16'h0abc, 5'd12, 1, 2'd2, 0, 1, 0, 8'h22, 0, "dbg halt");
    chk(glob_en == 1'b1, "R8 debug without disable-all", 32'(glob_en), 32'd1);
    // R4 R8: debug with return at PC 0 (wrap), disable-all, size code 3
    rdy_mode = 1;
    run_exit(0, 1, 0, 3'd0, 16'h0000, 5'd30, 1, 2'd3, 1, 0, 1, 8'h33, 0, "dbg ret wrap");
    chk(glob_en == 1'b0, "R8 disable-all clears", 32'(glob_en), 32'd0);
    repeat (3) @(negedge clk);
    chk(glob_en == 1'b0, "R8 stays cleared", 32'(glob_en), 32'd0);
    host_en_set = 1; @(negedge clk); host_en_set = 0;
    chk(glob_en == 1'b1, "R8 host sets enable", 32'(glob_en), 32'd1);
    // R9: both triggers at once, error wins
    rdy_mode = 0; irq_delay = 2;
    run_exit(1, 1, 0, 3'd6, 16'h7777, 5'd9, 1, 2'd1, 1, 1, 1, 8'h80, 0, "both");
    chk(glob_en == 1'b1, "R9 dropped debug no disable", 32'(glob_en), 32'd1);
    // R9: triggers during a running exit are ignored
    rdy_mode = 1; irq_delay = 10;
    run_exit(1, 0, 0, 3'd1, 16'h2222, 5'd1, 0, 2'd0, 0, 0, 0, 8'hc3, 1, "mid trig");
    chk(glob_en == 1'b1, "R9 ignored disable-all", 32'(glob_en), 32'd1);
    repeat (5) @(negedge clk);
    chk(!busy && !ctx_vld, "R9 no extra exit", 32'({busy, ctx_vld}), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule